// File: doc/BRIEF.md
# Dual-Source Interrupt Counter

This block raises a cartridge interrupt from one of two timing sources. In cycle mode a 16-bit down-counter, loaded a byte at a time, is stepped by each CPU cycle tick and requests an interrupt when it runs out. In line mode an 8-bit counter is stepped by filtered rising edges of PPU address line 12. On each such edge it either reloads from a latch or decrements, which makes it the scanline counter familiar from common cartridge mappers.

Software programs the block through four write-only registers. They sit at CPU addresses whose bits 15:12 are `C` and whose bits 1:0 pick the register; bits 11:2 are ignored. A control register chooses the source and sets the enable. An optional automatic mode turns the two counter-data writes into implicit disable and enable commands and locks out the explicit enable register. The block has no streaming data path. Its inputs are a plain write strobe, a one-clock CPU-cycle tick and the A12 level, and its only output is a level interrupt request.

Top module: `dual_src_irq_timer`

## Requirements
- R1: A write is decoded only when `wr_addr & 16'hF003` equals `16'hC000`, `16'hC001`, `16'hC002` or `16'hC003`; register index = `wr_addr[1:0]`; every other address has no effect.
- R2: A write to index 2 sets enable = data bit 0, source = data bit 1 (0 cycle ticks, 1 A12 lines) and auto flag = data bit 2.
- R3: In cycle mode, index 0 loads count bits 7:0 and index 1 loads count bits 15:8.
- R4: In cycle mode, while enabled, each `m2_tick` decrements the count; the decrement that reaches zero asserts `irq_out` at that same clock edge; the count then holds at zero and does not move while disabled.
- R5: In line mode, index 0 sets a reload flag and index 1 writes the 8-bit reload latch.
- R6: In line mode, each filtered A12 rise loads the latch if the count is zero or the reload flag is set (clearing the flag), else decrements; a resulting zero asserts `irq_out` if enabled.
- R7: An A12 rise is counted only when A12 was low for at least 3 `m2_tick` pulses before it.
- R8: With the auto flag set, index 0 clears the enable and index 1 sets it; in cycle mode this stops counting, in line mode counting continues and only the interrupt is gated.
- R9: Index 3 sets enable = data bit 0, but is ignored while the auto flag is set.
- R10: Any write that clears the enable also clears a pending `irq_out`; reset clears the counters, flags and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one clock per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| m2_tick | input | 1 | One-clock pulse per CPU cycle |
| ppu_a12 | input | 1 | PPU address line 12 level, synchronous to clk |
| irq_out | output | 1 | Interrupt request, active high, level |

## Verification
The bench loads counts through mirrored register addresses and checks that the interrupt appears on the exact tick that reaches zero, then stays while the count holds. A decoder that ignored the top address nibble would let a stray write to `D003` acknowledge the interrupt. It drives short A12 low pulses between real lines; a filter that let them through would make the interrupt fire lines early. In auto mode it checks that the explicit enable write is ignored, that cycle counting freezes while disabled, and that the line counter keeps counting while its interrupt is gated. A design that froze the line counter would reload instead of reaching zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_LINE = 1'b1} src_e;
  typedef enum logic [1:0] {
    OFS_CNT_LO = 2'd0,
    OFS_CNT_HI = 2'd1,
    OFS_CTRL   = 2'd2,
    OFS_ENABLE = 2'd3
  } ofs_e;
endpackage

// File: rtl/irqc_reg_decode.sv
module irqc_reg_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'hF003,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output ofs_e              sel,
  output logic              en_q,
  output src_e              src_q,
  output logic              auto_q,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              dis_wr
);
  localparam logic [ADDR_W-1:0] SEL_BITS = ADDR_W'(3);

  always_comb begin
    hit = wr_en && ((wr_addr & ADDR_MASK & ~SEL_BITS) == ADDR_BASE);
    sel = ofs_e'(wr_addr[1:0]);
    lo_wr = hit && (sel == OFS_CNT_LO);
    hi_wr = hit && (sel == OFS_CNT_HI);
    dis_wr = hit && (((sel == OFS_CNT_LO) && auto_q) ||
                     ((sel == OFS_CTRL) && !wr_data[0]) ||
                     ((sel == OFS_ENABLE) && !auto_q && !wr_data[0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= SRC_CYCLE;
      auto_q <= 1'b0;
    end else if (hit) begin
      unique case (sel)
        OFS_CNT_LO: if (auto_q) en_q <= 1'b0;
        OFS_CNT_HI: if (auto_q) en_q <= 1'b1;
        OFS_CTRL: begin
          en_q   <= wr_data[0];
          src_q  <= src_e'(wr_data[1]);
          auto_q <= wr_data[2];
        end
        OFS_ENABLE: if (!auto_q) en_q <= wr_data[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_cycle_cnt.sv
module irqc_cycle_cnt #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  cnt,
  output logic              zero_evt
);
  logic step;

  always_comb begin
    step     = run && tick && !lo_wr && !hi_wr && (cnt != '0);
    zero_evt = step && (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (lo_wr) begin
      cnt[DATA_W-1:0] <= data;
    end else if (hi_wr) begin
      cnt[CNT_W-1:DATA_W] <= data;
    end else if (step) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/irqc_a12_filter.sv
module irqc_a12_filter #(
  parameter int LOW_TICKS = 3,
  localparam int LC_W = $clog2(LOW_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12,
  input  logic tick,
  output logic rise
);
  logic            a12_q;
  logic [LC_W-1:0] low_cnt;
  logic            low_long;

  always_comb begin
    low_long = (low_cnt == LC_W'(LOW_TICKS));
    rise     = a12 && !a12_q && low_long;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a12_q   <= 1'b0;
      low_cnt <= '0;
    end else begin
      a12_q <= a12;
      if (a12) begin
        low_cnt <= '0;
      end else if (tick && !low_long) begin
        low_cnt <= low_cnt + LC_W'(1);
      end
    end
  end
endmodule

// File: rtl/irqc_line_cnt.sv
module irqc_line_cnt #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              reload_req,
  input  logic              latch_wr,
  input  logic [DATA_W-1:0] data,
  output logic              zero_evt
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] latch_q;
  logic              reload_q;
  logic [DATA_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt  = ((cnt == '0) || reload_q) ? latch_q : cnt - DATA_W'(1);
    zero_evt = rise && (cnt_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      latch_q  <= '0;
      reload_q <= 1'b0;
    end else begin
      if (latch_wr) latch_q <= data;
      if (rise) cnt <= cnt_nxt;
      if (reload_req) reload_q <= 1'b1;
      else if (rise) reload_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_src_irq_timer.sv
module dual_src_irq_timer
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LOW_TICKS = 3,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              m2_tick,
  input  logic              ppu_a12,
  output logic              irq_out
);
  logic       reg_hit;
  ofs_e       reg_sel;
  logic       en_q;
  src_e       src_q;
  logic       auto_q;
  logic       lo_wr;
  logic       hi_wr;
  logic       dis_wr;
  logic       on_cycle;
  logic       on_line;
  logic       m2_run;
  logic       m2_lo;
  logic       m2_hi;
  logic [CNT_W-1:0] m2_cnt;
  logic       m2_evt;
  logic       a12_rise;
  logic       line_tick;
  logic       line_zero;
  logic       line_evt;
  logic       irq_q;

  irqc_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit(reg_hit), .sel(reg_sel), .en_q(en_q),
    .src_q(src_q), .auto_q(auto_q), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .dis_wr(dis_wr)
  );

  always_comb begin
    on_cycle  = (src_q == SRC_CYCLE);
    on_line   = (src_q == SRC_LINE);
    m2_run    = en_q && on_cycle;
    m2_lo     = lo_wr && on_cycle;
    m2_hi     = hi_wr && on_cycle;
    line_tick = a12_rise && on_line;
    line_evt  = line_zero && en_q;
  end

  irqc_cycle_cnt #(.DATA_W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(m2_run), .tick(m2_tick),
    .lo_wr(m2_lo), .hi_wr(m2_hi), .data(wr_data), .cnt(m2_cnt),
    .zero_evt(m2_evt)
  );

  irqc_a12_filter #(.LOW_TICKS(LOW_TICKS)) u_flt (
    .clk(clk), .rst_n(rst_n), .a12(ppu_a12), .tick(m2_tick), .rise(a12_rise)
  );

  irqc_line_cnt #(.DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .rise(line_tick),
    .reload_req(lo_wr && on_line), .latch_wr(hi_wr && on_line),
    .data(wr_data), .zero_evt(line_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (dis_wr) irq_q <= 1'b0;
    else if (m2_evt || line_evt) irq_q <= 1'b1;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             en_q,
  input logic             auto_q,
  input logic             reg_hit,
  input logic [1:0]       reg_sel,
  input logic             m2_run,
  input logic             m2_lo,
  input logic             m2_hi,
  input logic [CNT_W-1:0] m2_cnt,
  input logic             m2_evt,
  input logic             line_evt,
  input logic             line_tick
);
  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(m2_evt || line_evt));

  assert_cycle_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_cnt == '0 && !m2_lo && !m2_hi) |=> (m2_cnt == '0));

  assert_cycle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!m2_run && !m2_lo && !m2_hi) |=> $stable(m2_cnt));

  assert_enable_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && reg_sel == 2'd3 && auto_q) |=> $stable(en_q));

  assert_disable_acks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !irq_out);

  assert_single_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> !line_tick);
endmodule

bind dual_src_irq_timer irqc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .en_q(en_q),
  .auto_q(auto_q), .reg_hit(reg_hit), .reg_sel(reg_sel),
  .m2_run(m2_run), .m2_lo(m2_lo), .m2_hi(m2_hi), .m2_cnt(m2_cnt),
  .m2_evt(m2_evt), .line_evt(line_evt), .line_tick(line_tick)
);

// File: tb/dual_src_irq_timer_tb.sv
`timescale 1ns/1ps
module dual_src_irq_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        m2_tick = 1'b0;
  logic        ppu_a12 = 1'b0;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {logic exp; string tag;} item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  dual_src_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .m2_tick(m2_tick), .ppu_a12(ppu_a12), .irq_out(irq_out)
  );

  // monitor: compare queued expectations at the falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (irq_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: irq_out=%0b expected=%0b", it.tag, irq_out, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d; m2_tick = 1'b0;
  endtask

  task automatic tk();
    @(posedge clk); #1;
    wr_en = 1'b0; m2_tick = 1'b1;
  endtask

  task automatic chk(input logic exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = 1'b0; m2_tick = 1'b0;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic line();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      wr_en = 1'b0; m2_tick = 1'b1; ppu_a12 = 1'b0;
    end
    @(posedge clk); #1;
    m2_tick = 1'b0; ppu_a12 = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic glitch();
    @(posedge clk); #1;
    wr_en = 1'b0; m2_tick = 1'b1; ppu_a12 = 1'b0;
    @(posedge clk); #1;
    m2_tick = 1'b0; ppu_a12 = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: timed out");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(1'b0, "R10 reset state");

    // cycle mode, mirrored low-byte address
    wr(16'hC002, 8'h00);
    wr(16'hC7F4, 8'h05);
    wr(16'hC001, 8'h00);
    wr(16'hC002, 8'h01);
    repeat (4) tk();
    chk(1'b0, "R4 one count left");
    tk();
    chk(1'b1, "R1 R3 R4 zero reached after 5 ticks");
    repeat (3) tk();
    chk(1'b1, "R4 holds at zero, IRQ kept");
    wr(16'hD003, 8'h00);
    chk(1'b1, "R1 D003 not decoded");
    wr(16'h8003, 8'h00);
    chk(1'b1, "R1 8003 not decoded");
    wr(16'hC003, 8'h00);
    chk(1'b0, "R9 R10 C003 disable acks IRQ");

    // high byte: 256 ticks
    wr(16'hC000, 8'h00);
    wr(16'hC001, 8'h01);
    wr(16'hC002, 8'h01);
    repeat (255) tk();
    chk(1'b0, "R3 high byte, 1 left");
    tk();
    chk(1'b1, "R3 high byte zero");
    wr(16'hC002, 8'h00);
    chk(1'b0, "R2 R10 control disable acks");

    // disabled counter does not move
    wr(16'hC000, 8'h02);
    wr(16'hC001, 8'h00);
    repeat (5) tk();
    chk(1'b0, "R4 no IRQ while disabled");
    wr(16'hC003, 8'h01);
    tk();
    chk(1'b0, "R9 C003 enable, one tick");
    tk();
    chk(1'b1, "R4 count frozen while disabled");
    wr(16'hC003, 8'h00);

    // auto flag, cycle mode
    wr(16'hC002, 8'h05);
    wr(16'hC001, 8'h00);
    wr(16'hC000, 8'h02);
    repeat (3) tk();
    chk(1'b0, "R8 auto C000 stops counting");
    wr(16'hC001, 8'h00);
    wr(16'hC003, 8'h00);
    tk();
    chk(1'b0, "R8 auto C001 enables");
    tk();
    chk(1'b1, "R9 C003 ignored under auto");
    wr(16'hC000, 8'h07);
    chk(1'b0, "R8 R10 auto C000 acks");

    // line mode
    wr(16'hC002, 8'h02);
    wr(16'hC001, 8'h02);
    wr(16'hC000, 8'h00);
    wr(16'hC002, 8'h03);
    line(); chk(1'b0, "R2 R6 first line loads latch 2");
    line(); chk(1'b0, "R6 decrement to 1");
    line(); chk(1'b1, "R6 zero fires IRQ");
    wr(16'hC003, 8'h00);
    chk(1'b0, "R10 line IRQ acked");
    wr(16'hC003, 8'h01);
    line(); chk(1'b0, "R6 zero count reloads");
    glitch(); glitch();
    chk(1'b0, "R7 short low ignored");
    line(); chk(1'b0, "R7 filtered line to 1");
    line(); chk(1'b1, "R7 only filtered rises counted");
    wr(16'hC003, 8'h00);

    // auto flag, line mode
    wr(16'hC002, 8'h07);
    wr(16'hC000, 8'h00);
    line(); chk(1'b0, "R8 line reload while gated");
    line(); chk(1'b0, "R8 line counts while gated");
    wr(16'hC001, 8'h05);
    wr(16'hC003, 8'h00);
    line(); chk(1'b1, "R8 R9 counting continued, IRQ re-enabled");
    wr(16'hC000, 8'h00);
    chk(1'b0, "R8 auto C000 acks in line mode");

    // reload flag
    wr(16'hC002, 8'h03);
    wr(16'hC001, 8'h01);
    line(); chk(1'b0, "R5 reload to latch 1");
    wr(16'hC000, 8'h00);
    line(); chk(1'b0, "R5 reload flag forces reload");
    line(); chk(1'b1, "R5 decrement to zero");

    // reset while pending
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk(1'b0, "R10 reset clears IRQ");
    wr(16'hC002, 8'h01);
    tk(); tk();
    chk(1'b0, "R10 reset cleared count");

    @(negedge clk); @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule